// File: doc/BRIEF.md
# VGA Sync and Video-Gate Generator

This block produces horizontal and vertical sync for a 640x480, 60 Hz style raster directly from a 20 MHz system clock. It does not use a pixel clock. A free-running line timer counts 636 cycles per line and shapes the horizontal sync pulse. It also emits an end-of-line event. A line counter advanced by that event drives vertical sync and decides which lines are visible.

On each visible line the block opens a video gate window. The window has a fixed cycle count and starts a fixed number of cycles after the horizontal sync falling edge. While the gate is open, an external pixel source drives an 8-bit AARRGGBB colour word. The block passes it through one register and forces it to zero everywhere else. A separate flag marks the first visible line of each frame, so a frame-buffer reader can align to it.

All timing values are parameters. The line numbering runs 1 to the frame length, and line 0 exists only between reset and the first end-of-line event.

Top module: `vga_sync_gen`

## Requirements
- R1: hsync_o has a period of exactly TOP+1 clock cycles (636 with defaults). The line timer counts 0..TOP and then wraps to 0.
- R2: hsync_o is high while the timer value lies in [HS_CMP, TOP-1] and low otherwise. The low phase therefore lasts HS_CMP+1 cycles (76 by default), measured from the falling edge to the rising edge.
- R3: Each end-of-line event (timer at TOP) first clears the line number if it equals LINES and then adds one. The numbers run 1..LINES (525), so exactly LINES hsync falling edges separate two vsync falling edges.
- R4: vsync_o is low while the line number is below VS_END (3), which covers two lines per frame, and high on every other line. vsync_o changes only in the cycle after an hsync falling edge.
- R5: video_gate_o opens only on lines VIS_FIRST (35) through VIS_END-1 (514). That gives VIS_END-VIS_FIRST gated lines per frame, all with vsync_o high.
- R6: On a gated line, video_gate_o rises exactly GATE_DLY (113) cycles after the hsync falling edge and stays high for exactly GATE_LEN (500) cycles. The whole window lies inside the hsync high phase.
- R7: first_line_o rises in the cycle after the hsync falling edge that starts line VIS_FIRST. It falls in the same cycle as that line's video_gate_o falls and is low at all other times.
- R8: color_o equals the value pix_i held at the preceding rising clock edge while video_gate_o is high, and is 0x00 while video_gate_o is low.
- R9: While rst_ni is low, all outputs are 0 and the timer and line number are 0. After release the timer restarts at 0, so the first hsync falling edge comes TOP cycles after the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (20 MHz for the default timing) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 8 | Colour word from the pixel source, AARRGGBB |
| hsync_o | output | 1 | Horizontal sync, low pulse at line start |
| vsync_o | output | 1 | Vertical sync, low for the first lines of a frame |
| video_gate_o | output | 1 | High during the active video window of a visible line |
| first_line_o | output | 1 | High on the first visible line until its window closes |
| color_o | output | 8 | Gated colour output, zero outside the window |

## Verification
Every output is a register loaded from next-state logic, so each output edge shows up at the first sampling point after the clock edge that moves the timer to the deciding value. vsync_o and first_line_o therefore change one cycle after the hsync falling edge, the gate opens GATE_DLY cycles after it, and color_o reflects pix_i from one edge earlier. The bench samples on the falling clock edge. It measures each of these distances as a difference of cycle counts taken from edge events of the outputs themselves. It drives pix_i just after each rising edge and keeps the value that the edge captured for the colour comparison. The bench uses scaled parameters so that several whole frames fit in the run. It also applies a reset at a random point in mid-frame and then checks how long the block takes to restart.

// File: rtl/vga_sync_pkg.sv
package vga_sync_pkg;
  typedef struct packed {
    logic hs;
    logic vs;
    logic gate;
    logic first;
  } sync_t;
endpackage

// File: rtl/vga_line_timer.sv
module vga_line_timer #(
  parameter int unsigned TW     = 16,
  parameter int unsigned TOP    = 635,
  parameter int unsigned HS_CMP = 75
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [TW-1:0] cnt_nxt_o,
  output logic          eol_o,
  output logic          hs_nxt_o
);
  localparam logic [TW-1:0] TopC = TW'(TOP);
  localparam logic [TW-1:0] CmpC = TW'(HS_CMP);

  logic [TW-1:0] cnt_q;

  assign eol_o     = (cnt_q == TopC);
  assign cnt_nxt_o = eol_o ? '0 : cnt_q + TW'(1);
  // high from compare match up to, not including, TOP
  assign hs_nxt_o  = (cnt_nxt_o >= CmpC) && (cnt_nxt_o != TopC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/vga_line_seq.sv
module vga_line_seq #(
  parameter int unsigned LINES     = 525,
  parameter int unsigned VS_END    = 3,
  parameter int unsigned VIS_FIRST = 35,
  parameter int unsigned VIS_END   = 515
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eol_i,
  output logic vs_nxt_o,
  output logic vis_nxt_o,
  output logic first_nxt_o
);
  localparam int unsigned LW = $clog2(LINES + 1);
  localparam logic [LW-1:0] LinesC = LW'(LINES);
  localparam logic [LW-1:0] VsEndC = LW'(VS_END);
  localparam logic [LW-1:0] VisFC  = LW'(VIS_FIRST);
  localparam logic [LW-1:0] VisEC  = LW'(VIS_END);

  logic [LW-1:0] line_q, line_nxt;

  // clear at frame end, then advance: numbering 1..LINES
  assign line_nxt    = eol_i ? ((line_q == LinesC) ? LW'(1) : line_q + LW'(1)) : line_q;
  assign vs_nxt_o    = (line_nxt >= VsEndC);
  assign vis_nxt_o   = (line_nxt >= VisFC) && (line_nxt < VisEC);
  assign first_nxt_o = (line_nxt == VisFC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_nxt;
  end
endmodule

// File: rtl/vga_gate_win.sv
module vga_gate_win #(
  parameter int unsigned TW       = 16,
  parameter int unsigned GATE_DLY = 113,
  parameter int unsigned GATE_LEN = 500
) (
  input  logic [TW-1:0] cnt_nxt_i,
  input  logic          vis_nxt_i,
  input  logic          first_nxt_i,
  output logic          gate_nxt_o,
  output logic          first_nxt_o
);
  // timer value 0 lands one cycle after the hsync fall
  localparam logic [TW-1:0] OpenC  = TW'(GATE_DLY - 1);
  localparam logic [TW-1:0] CloseC = TW'(GATE_DLY - 1 + GATE_LEN);

  logic in_win;

  assign in_win      = (cnt_nxt_i >= OpenC) && (cnt_nxt_i < CloseC);
  assign gate_nxt_o  = vis_nxt_i && in_win;
  assign first_nxt_o = first_nxt_i && (cnt_nxt_i < CloseC);
endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen #(
  parameter int unsigned TW        = 16,
  parameter int unsigned TOP       = 635,
  parameter int unsigned HS_CMP    = 75,
  parameter int unsigned LINES     = 525,
  parameter int unsigned VS_END    = 3,
  parameter int unsigned VIS_FIRST = 35,
  parameter int unsigned VIS_END   = 515,
  parameter int unsigned GATE_DLY  = 113,
  parameter int unsigned GATE_LEN  = 500,
  parameter int unsigned PW        = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] pix_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          video_gate_o,
  output logic          first_line_o,
  output logic [PW-1:0] color_o
);
  import vga_sync_pkg::*;

  logic [TW-1:0] cnt_nxt;
  logic          eol, hs_nxt, vs_nxt, vis_nxt, first_line_nxt;
  sync_t         sync_nxt, sync_q;
  logic [PW-1:0] color_q;

  vga_line_timer #(.TW(TW), .TOP(TOP), .HS_CMP(HS_CMP)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_nxt_o (cnt_nxt),
    .eol_o     (eol),
    .hs_nxt_o  (hs_nxt)
  );

  vga_line_seq #(
    .LINES(LINES), .VS_END(VS_END), .VIS_FIRST(VIS_FIRST), .VIS_END(VIS_END)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eol_i       (eol),
    .vs_nxt_o    (vs_nxt),
    .vis_nxt_o   (vis_nxt),
    .first_nxt_o (first_line_nxt)
  );

  vga_gate_win #(.TW(TW), .GATE_DLY(GATE_DLY), .GATE_LEN(GATE_LEN)) u_win (
    .cnt_nxt_i   (cnt_nxt),
    .vis_nxt_i   (vis_nxt),
    .first_nxt_i (first_line_nxt),
    .gate_nxt_o  (sync_nxt.gate),
    .first_nxt_o (sync_nxt.first)
  );

  assign sync_nxt.hs = hs_nxt;
  assign sync_nxt.vs = vs_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      color_q <= '0;
    end else begin
      sync_q  <= sync_nxt;
      color_q <= sync_nxt.gate ? pix_i : '0;
    end
  end

  assign hsync_o      = sync_q.hs;
  assign vsync_o      = sync_q.vs;
  assign video_gate_o = sync_q.gate;
  assign first_line_o = sync_q.first;
  assign color_o      = color_q;
endmodule

// File: rtl/vga_sync_chk.sv
module vga_sync_chk #(
  parameter int unsigned PW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          video_gate_o,
  input logic          first_line_o,
  input logic [PW-1:0] color_o
);
  AST_HS_LOW_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_o) |=> !hsync_o); // R2
  AST_VS_AFTER_HS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |-> (!hsync_o && $past(!hsync_o))); // R4
  AST_GATE_IN_VS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    video_gate_o |-> vsync_o); // R5
  AST_GATE_IN_HS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    video_gate_o |-> hsync_o); // R6
  AST_FIRST_IN_VS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_line_o |-> vsync_o); // R7
  AST_FIRST_ENDS_WITH_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(video_gate_o) |-> !first_line_o); // R7
  AST_COLOR_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !video_gate_o |-> (color_o == '0)); // R8
endmodule

bind vga_sync_gen vga_sync_chk #(.PW(PW)) u_sync_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hsync_o      (hsync_o),
  .vsync_o      (vsync_o),
  .video_gate_o (video_gate_o),
  .first_line_o (first_line_o),
  .color_o      (color_o)
);

// File: tb/tb_vga_sync_gen.sv
`timescale 1ns/1ps
module tb_vga_sync_gen;
  localparam int TOP = 63, HS_CMP = 7, LINES = 20, VS_END = 3;
  localparam int VIS_FIRST = 6, VIS_END = 16, GATE_DLY = 12, GATE_LEN = 40;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] pix_i = '0, pix_last = '0;
  logic hsync_o, vsync_o, video_gate_o, first_line_o;
  logic [7:0] color_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  vga_sync_gen #(
    .TW(16), .TOP(TOP), .HS_CMP(HS_CMP), .LINES(LINES), .VS_END(VS_END),
    .VIS_FIRST(VIS_FIRST), .VIS_END(VIS_END), .GATE_DLY(GATE_DLY),
    .GATE_LEN(GATE_LEN), .PW(8)
  ) dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // bench-side expectations
  function automatic int exp_frame_gates();
    return VIS_END - VIS_FIRST;
  endfunction
  function automatic int exp_vs_low_lines();
    return VS_END - 1;
  endfunction

  // pixel driver: drive just after each rising edge, remember captured value
  initial begin
    void'($urandom(32'h5eed_1234));
    forever begin
      @(posedge clk_i);
      pix_last = pix_i;
      #2 pix_i = 8'($urandom);
    end
  end

  // monitor
  int k = 0, last_fall = 0, gate_rise = 0;
  int falls_in_frame = 0, vs_low_falls = 0, gates_in_frame = 0;
  bit have_fall = 0, synced = 0;
  logic hs_p = 0, vs_p = 0, g_p = 0, f_p = 0;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      // R9: everything held at zero during reset
      chk(!hsync_o && !vsync_o && !video_gate_o && !first_line_o && color_o == 0,
          "R9", {hsync_o, vsync_o, video_gate_o, first_line_o, color_o}, 0);
      k = 0; have_fall = 0; synced = 0;
      falls_in_frame = 0; vs_low_falls = 0; gates_in_frame = 0;
      hs_p = 0; vs_p = 0; g_p = 0; f_p = 0;
    end else begin
      k++;
      // R8 every cycle
      chk(color_o == (video_gate_o ? pix_last : 8'h00), "R8", color_o,
          video_gate_o ? pix_last : 0);
      if (hs_p && !hsync_o) begin
        if (have_fall) chk(k - last_fall == TOP + 1, "R1", k - last_fall, TOP + 1);
        else           chk(k == TOP, "R9", k, TOP);
        have_fall = 1; last_fall = k;
        falls_in_frame++;
        if (!vsync_o) vs_low_falls++;
      end
      if (!hs_p && hsync_o && have_fall)
        chk(k - last_fall == HS_CMP + 1, "R2", k - last_fall, HS_CMP + 1);
      if (vs_p && !vsync_o) begin
        chk(k == last_fall + 1, "R4", k, last_fall + 1);
        if (synced) begin
          chk(falls_in_frame == LINES, "R3", falls_in_frame, LINES);
          chk(vs_low_falls == exp_vs_low_lines(), "R4", vs_low_falls, exp_vs_low_lines());
          chk(gates_in_frame == exp_frame_gates(), "R5", gates_in_frame, exp_frame_gates());
        end
        synced = 1; falls_in_frame = 0; vs_low_falls = 0; gates_in_frame = 0;
      end
      if (!vs_p && vsync_o && have_fall)
        chk(k == last_fall + 1, "R4", k, last_fall + 1);
      if (!g_p && video_gate_o) begin
        chk(k - last_fall == GATE_DLY, "R6", k - last_fall, GATE_DLY);
        if (synced)
          chk(falls_in_frame + 1 >= VIS_FIRST && falls_in_frame + 1 < VIS_END,
              "R5", falls_in_frame + 1, VIS_FIRST);
        gates_in_frame++; gate_rise = k;
      end
      if (g_p && !video_gate_o)
        chk(k - gate_rise == GATE_LEN, "R6", k - gate_rise, GATE_LEN);
      if (!f_p && first_line_o) begin
        chk(k == last_fall + 1, "R7", k, last_fall + 1);
        if (synced) chk(falls_in_frame + 1 == VIS_FIRST, "R7", falls_in_frame + 1, VIS_FIRST);
      end
      if (f_p && !first_line_o)
        chk(g_p && !video_gate_o, "R7", video_gate_o, 0);
      hs_p = hsync_o; vs_p = vsync_o; g_p = video_gate_o; f_p = first_line_o;
    end
  end

  initial begin
    repeat (4) @(negedge clk_i);
    #3 rst_ni = 1'b1;
    repeat (4 * LINES * (TOP + 1) + 300) @(negedge clk_i);
    // mid-frame reset at a random point (R9)
    repeat (int'($urandom_range(50, 2000))) @(negedge clk_i);
    #3 rst_ni = 1'b0;
    repeat (5) @(negedge clk_i);
    #3 rst_ni = 1'b1;
    repeat (3 * LINES * (TOP + 1) + 200) @(negedge clk_i);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule